// File: doc/BRIEF.md
# Booth Multiplier Operand Shift Register

This block holds the multiplier operand of a Booth multiplier and feeds it bit by bit toward the Booth controller. It is a chain of `WIDTH+1` storage stages. Each stage holds one ternary symbol: zero, one, or an end marker. The end marker tells the controller that the operand is used up, so the controller needs no iteration counter. Commands arrive from the controller side as one-hot words. Each command is forwarded unchanged, one cycle later, to the accumulator side of the multiplier.

An initialize command loads the operand from the parallel input `a_i`. Stages below the requested length take the operand bits, the stage at the length index takes the end marker, and every stage above it takes zero. Each of the other five commands (add, add twice, subtract, subtract twice, shift) moves every stage one place toward the controller and fills the top stage with zero. The symbol that leaves the bottom stage is presented on `bit_o` with `bit_valid_o`.

The operand length is chosen per operation on `sent_pos_i`. Short operands therefore stop early, and a wider operand never costs extra cycles when a narrow one is in use.

Top module: `booth_mplier_shreg`

## Requirements
- R1: Every stored symbol and `bit_o` use a 3-bit one-hot code: zero = 3'b001, one = 3'b010, end marker = 3'b100. After reset, all stages hold zero, `bit_o` is zero, and both `bit_valid_o` and `cmd_valid_o` are low.
- R2: An initialize command (command bit 0) with length L loads stage i (i < L) with the symbol for `a_i[i]`. After that load, the first L shift-type commands deliver those symbols on `bit_o` in order, starting from bit 0.
- R3: On initialize, stage L takes the end marker. It appears on `bit_o` with the (L+1)-th shift-type command after the load, and the chain then holds exactly one end marker.
- R4: A `sent_pos_i` value greater than `WIDTH` is treated as `WIDTH`.
- R5: Each of the commands on bits 1 to 5 (add, add twice, subtract, subtract twice, shift) moves the chain one stage toward the output. In the next cycle, the symbol that was in stage 0 is presented on `bit_o` with `bit_valid_o` high.
- R6: The top stage fills with the zero symbol on every shift. Once the end marker has been delivered, further shifts deliver zero.
- R7: Every command with `cmd_valid_i` high appears on `cmd_o` with `cmd_valid_o` high in the next cycle. In a cycle with no command, `cmd_valid_o` is low.
- R8: Initialize commands and idle cycles do not raise `bit_valid_o`. Idle cycles leave the stored contents unchanged.
- R9: At most one end marker is stored at any time. A new initialize replaces every stage, including stages left over from an unfinished operand.
- R10: A length of 0 places the end marker in stage 0, so the first shift delivers it at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | WIDTH | Parallel multiplier operand |
| sent_pos_i | input | $clog2(WIDTH+1) | Operand length, sampled on initialize |
| cmd_valid_i | input | 1 | Command present from the controller side |
| cmd_i | input | 6 | One-hot command: bit0 init, bit1 add, bit2 add twice, bit3 subtract, bit4 subtract twice, bit5 shift |
| cmd_valid_o | output | 1 | Forwarded command present |
| cmd_o | output | 6 | Forwarded command toward the accumulator |
| bit_valid_o | output | 1 | Symbol on `bit_o` was just shifted out |
| bit_o | output | 3 | Symbol leaving stage 0 |

## Verification
The bench targets the length boundaries. At the full width, the end marker lives in the extra top stage. At length 0, it must come out first. Out-of-range lengths must fold to the full width: a design that dropped the fallback would lose the marker or place it wrongly, and the controller would never stop.

The bench also reloads in the middle of an operand. A design that left stale stages untouched would deliver two markers or old bits.

Idle gaps are placed between shifts. A design that shifted on idle cycles or on initialize would skip operand bits.

All five shift-type commands are rotated through the tests. A decoder that missed one of them would stall the stream.

// File: rtl/mls_pkg.sv
package mls_pkg;

  // Ternary stored symbol, one-hot
  typedef logic [2:0] sym_t;
  localparam sym_t SYM_ZERO = 3'b001;
  localparam sym_t SYM_ONE  = 3'b010;
  localparam sym_t SYM_SENT = 3'b100;

  // One-hot command word; bit 0 is initialize, bits 1..5 all shift
  localparam int CMD_W  = 6;
  localparam int C_INIT = 0;

  function automatic sym_t bit2sym(input logic b);
    return b ? SYM_ONE : SYM_ZERO;
  endfunction

endpackage

// File: rtl/mls_stage.sv
module mls_stage
  import mls_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic shift_en,
  input  sym_t load_sym,
  input  sym_t left_sym,
  output sym_t sym_o
);

  sym_t sym_q;
  sym_t sym_n;
  logic sym_en;

  always_comb begin
    sym_n  = sym_q;
    sym_en = load_en | shift_en;
    if (load_en)
      sym_n = load_sym;
    else if (shift_en)
      sym_n = left_sym;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sym_q <= SYM_ZERO;
    else if (sym_en)
      sym_q <= sym_n;
  end

  assign sym_o = sym_q;

  AST_SYM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sym_q)); // R1

endmodule

// File: rtl/mls_len_sel.sv
module mls_len_sel
  import mls_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int POS_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0]         a_i,
  input  logic [POS_W-1:0]         pos_i,
  output logic [WIDTH:0][2:0]      load_syms
);

  localparam logic [POS_W-1:0] MAX_POS = POS_W'(WIDTH);

  logic [POS_W-1:0] eff_pos;

  // Out-of-range length folds to the full width
  always_comb begin
    eff_pos = (pos_i > MAX_POS) ? MAX_POS : pos_i;
  end

  for (genvar i = 0; i <= WIDTH; i++) begin : g_sym
    localparam logic [POS_W-1:0] IPOS = POS_W'(i);
    if (i < WIDTH) begin : g_data
      assign load_syms[i] = (IPOS < eff_pos)  ? bit2sym(a_i[i]) :
                            (IPOS == eff_pos) ? SYM_SENT : SYM_ZERO;
    end else begin : g_top
      assign load_syms[i] = (IPOS == eff_pos) ? SYM_SENT : SYM_ZERO;
    end
  end

endmodule

// File: rtl/mls_emit.sv
module mls_emit
  import mls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  sym_t             tail_sym,
  output logic             cmd_valid_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             bit_valid_o,
  output sym_t             bit_o
);

  logic             cvld_q, cvld_n;
  logic [CMD_W-1:0] cmd_q, cmd_n;
  logic             bvld_q, bvld_n;
  sym_t             bit_q, bit_n;

  always_comb begin
    cvld_n = cmd_valid_i;
    cmd_n  = cmd_valid_i ? cmd_i : cmd_q;
    bvld_n = cmd_valid_i & ~cmd_i[C_INIT];
    bit_n  = bvld_n ? tail_sym : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cvld_q <= 1'b0;
      cmd_q  <= '0;
      bvld_q <= 1'b0;
      bit_q  <= SYM_ZERO;
    end else begin
      cvld_q <= cvld_n;
      bvld_q <= bvld_n;
      if (cmd_valid_i) cmd_q <= cmd_n;
      if (bvld_n)      bit_q <= bit_n;
    end
  end

  assign cmd_valid_o = cvld_q;
  assign cmd_o       = cmd_q;
  assign bit_valid_o = bvld_q;
  assign bit_o       = bit_q;

  AST_CMD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i |=> (cmd_valid_o && cmd_o == $past(cmd_i))); // R7
  AST_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid_i |=> !cmd_valid_o); // R7
  AST_SHIFT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && !cmd_i[C_INIT]) |=> bit_valid_o); // R5
  AST_INIT_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid_i || cmd_i[C_INIT]) |=> !bit_valid_o); // R8

endmodule

// File: rtl/booth_mplier_shreg.sv
module booth_mplier_shreg
  import mls_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WIDTH-1:0]             a_i,
  input  logic [$clog2(WIDTH+1)-1:0]   sent_pos_i,
  input  logic                         cmd_valid_i,
  input  logic [5:0]                   cmd_i,
  output logic                         cmd_valid_o,
  output logic [5:0]                   cmd_o,
  output logic                         bit_valid_o,
  output logic [2:0]                   bit_o
);

  localparam int POS_W  = $clog2(WIDTH + 1);
  localparam int STAGES = WIDTH + 1;

  // Asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic load_en, shift_en;
  logic [WIDTH:0][2:0] load_syms;
  logic [WIDTH:0][2:0] chain_q;
  logic [STAGES-1:0]   sent_vec;

  always_comb begin
    load_en  = cmd_valid_i & cmd_i[C_INIT];
    shift_en = cmd_valid_i & (|cmd_i[CMD_W-1:1]);
  end

  mls_len_sel #(.WIDTH(WIDTH), .POS_W(POS_W)) i_len_sel (
    .a_i       (a_i),
    .pos_i     (sent_pos_i),
    .load_syms (load_syms)
  );

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    sym_t left_sym;
    if (i == STAGES - 1) begin : g_top
      assign left_sym = SYM_ZERO;
    end else begin : g_mid
      assign left_sym = chain_q[i+1];
    end

    mls_stage i_stage (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .load_en  (load_en),
      .shift_en (shift_en),
      .load_sym (load_syms[i]),
      .left_sym (left_sym),
      .sym_o    (chain_q[i])
    );

    assign sent_vec[i] = chain_q[i][2];
  end

  mls_emit i_emit (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .tail_sym    (chain_q[0]),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o),
    .bit_valid_o (bit_valid_o),
    .bit_o       (bit_o)
  );

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_valid_i |-> $onehot(cmd_i)); // R7
  AST_SENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(sent_vec) <= 1); // R9
  AST_INIT_ONE_SENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_en |=> ($countones(sent_vec) == 1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmd_valid_i |=> $stable(chain_q)); // R8
  AST_TOP_FILL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (shift_en && !load_en) |=> (chain_q[STAGES-1] == SYM_ZERO)); // R6

endmodule

// File: tb/test_booth_mplier_shreg.sv
module test_booth_mplier_shreg;

  localparam int W = 8;
  localparam logic [2:0] S0 = 3'b001, S1 = 3'b010, SM = 3'b100;
  localparam logic [5:0] K_INIT = 6'b000001;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [W-1:0] a_in;
  logic [3:0] pos;
  logic       cvld;
  logic [5:0] cmd;
  logic       cvld_o;
  logic [5:0] cmd_o;
  logic       bvld_o;
  logic [2:0] bit_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  booth_mplier_shreg #(.WIDTH(W)) i_booth_mplier_shreg (
    .clk (clk), .rst_n (rst_n), .a_i (a_in), .sent_pos_i (pos),
    .cmd_valid_i (cvld), .cmd_i (cmd), .cmd_valid_o (cvld_o),
    .cmd_o (cmd_o), .bit_valid_o (bvld_o), .bit_o (bit_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_sym(input logic [W-1:0] a,
                                         input int len, input int k);
    int l = (len > W) ? W : len;
    if (k < l) return a[k] ? S1 : S0;
    if (k == l) return SM;
    return S0;
  endfunction

  // Drive on a falling edge; results are visible at the next falling edge
  task automatic do_cmd(input logic [5:0] c, input logic [W-1:0] a,
                        input logic [3:0] p);
    cvld = 1'b1; cmd = c; a_in = a; pos = p;
    @(negedge clk);
    cvld = 1'b0; cmd = '0;
  endtask

  function automatic logic [5:0] shcmd(input int k);
    return 6'b000010 << (k % 5);
  endfunction

  task automatic do_init(input logic [W-1:0] a, input logic [3:0] p);
    do_cmd(K_INIT, a, p);
    chk("R8", "no bit valid on init", {7'd0, bvld_o}, 8'd0);
    chk("R7", "init forwarded", {1'b0, cvld_o, cmd_o}, {2'b01, K_INIT});
  endtask

  task automatic shift_check(input logic [W-1:0] a, input int len,
                             input int k, input int step, input string tag);
    string req;
    int l = (len > W) ? W : len;
    logic [5:0] c = shcmd(step);
    do_cmd(c, '0, '0);
    if (tag != "") req = tag;
    else if (k < l) req = "R2";
    else if (k == l) req = "R3";
    else req = "R6";
    chk("R5", "bit valid on shift", {7'd0, bvld_o}, 8'd1);
    chk(req, "shifted symbol", {5'd0, bit_o}, {5'd0, exp_sym(a, len, k)});
    chk("R7", "shift forwarded", {1'b0, cvld_o, cmd_o}, {2'b01, c});
  endtask

  task automatic t_reset();
    chk("R1", "bit_valid after reset", {7'd0, bvld_o}, 8'd0);
    chk("R1", "cmd_valid after reset", {7'd0, cvld_o}, 8'd0);
    chk("R1", "bit after reset", {5'd0, bit_o}, {5'd0, S0});
    do_cmd(6'b100000, '0, '0);
    chk("R1", "reset contents are zero", {5'd0, bit_o}, {5'd0, S0});
  endtask

  task automatic t_run(input logic [W-1:0] a, input int len, input int n,
                       input string tag);
    do_init(a, 4'(len));
    for (int k = 0; k < n; k++) shift_check(a, len, k, k, (k == 0 || tag == "R4") ? tag : "");
  endtask

  task automatic t_idle();
    logic [W-1:0] a = 8'b1011_0110;
    do_init(a, 4'd6);
    for (int k = 0; k < 2; k++) shift_check(a, 6, k, k, "");
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R8", "idle no bit valid", {7'd0, bvld_o}, 8'd0);
      chk("R7", "idle no cmd valid", {7'd0, cvld_o}, 8'd0);
    end
    for (int k = 2; k < 8; k++) shift_check(a, 6, k, k, (k == 2) ? "R8" : "");
  endtask

  task automatic t_reinit();
    do_init(8'hFF, 4'd8);
    for (int k = 0; k < 3; k++) shift_check(8'hFF, 8, k, k, "");
    do_init(8'b0001_0010, 4'd5);
    for (int k = 0; k < 8; k++) shift_check(8'b0001_0010, 5, k, k + 2, (k >= 5) ? "R9" : "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cvld = 1'b0; cmd = '0; a_in = '0; pos = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_run(8'hA5, 8, 11, "");
    t_run(8'h3C, 3, 6, "");
    t_run(8'hD3, 12, 10, "R4");
    t_run(8'h5A, 15, 10, "R4");
    t_run(8'h81, 0, 3, "R10");
    t_run(8'h00, 8, 10, "");
    t_idle();
    t_reinit();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule